// File: doc/BRIEF.md
# Event Counter with Limit Interrupt

This block is a performance-monitoring counter. Software picks one line of an event input vector, loads a start value into the counter while it is stopped, programs a separate limit value, and sets the enable bit. From then on the counter adds one on every clock in which the selected event line is high. When an increment makes the count equal to the limit, a sticky status flag is set. If the interrupt-enable bit is set, the flag drives the interrupt output.

The counter does not stop at the limit. It keeps counting until software clears the enable bit, so events that arrive between the interrupt and its service are still counted. The counter wraps from all-ones to zero. Software never reads the live counter. It writes a trigger register, which copies the counter into a snapshot register in one cycle, and then reads the snapshot.

The register port is a plain single-cycle write strobe plus a combinational read address. There is no streaming data path, so the block has no valid/ready handshake and no back-pressure: every write takes effect at the clock edge on which `wr_en` is high.

Top module: `evt_lim_counter`

## Requirements
- R1: After reset the counter, the limit, the snapshot, the control register and the status flag are all zero, and `irq` is low.
- R2: A write to START (address 1) while the enable bit is clear loads `wr_data` into the counter. A write to START while enabled is ignored.
- R3: While enabled, the counter adds exactly one on each clock edge at which `evt_in[sel]` is high, and holds otherwise. `sel` is CTRL bits [2 +: SEL_W], the enable bit is CTRL bit 0, and CTRL is at address 0.
- R4: While the enable bit is clear, the counter holds its value whatever `evt_in` does.
- R5: The status flag (STATUS address 5, bit 0) is set when an increment produces a count equal to LIMIT (address 2). A load that makes the count equal to LIMIT does not set it.
- R6: Reaching the limit does not stop the counter; it keeps counting past the limit.
- R7: The status flag is sticky. Writing 1 to STATUS bit 0 clears it and writing 0 has no effect. If a match occurs in the same cycle as the clear, the set wins.
- R8: `irq` is high exactly when the status flag is set and the interrupt-enable bit (CTRL bit 1) is set.
- R9: Any write to TRIG (address 3) copies the counter value present before that clock edge into SNAP (address 4).
- R10: An increment from all-ones wraps the counter to zero. The wrap itself sets no flag; only an equality with LIMIT does.
- R11: Reads return CTRL, LIMIT, SNAP and STATUS at their addresses, zero-extended. All other addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| evt_in | input | EVT_W | Event condition lines |
| irq | output | 1 | Interrupt request |

## Verification
Each event select is run with three event patterns, and the count reached is compared with an arithmetic sum of the selected bit:
- A pseudo-random vector tells whether the correct line is picked and whether idle cycles are held.
- An all-ones vector tells whether exactly one is added per clock.
- A walking one tells whether neighbouring lines leak into the count.

Directed runs cover the corner cases:
- They cross the limit and read a snapshot taken during counting.
- They collide a clear with a match.
- They load a start value equal to the limit.
- They wrap the counter from all-ones, which separates an equality match from an overflow.

// File: rtl/evt_lim_pkg.sv
package evt_lim_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_START = 3'd1,
    A_LIMIT = 3'd2,
    A_TRIG  = 3'd3,
    A_SNAP  = 3'd4,
    A_STAT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/evt_lim_mux.sv
module evt_lim_mux #(
  parameter int EVT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic [EVT_W-1:0] evt,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [EVT_W-1:0] pick;
  for (genvar g = 0; g < EVT_W; g++) begin : g_line
    assign pick[g] = evt[g] & (sel == SEL_W'(g));
  end
  assign hit = |pick;
endmodule

// File: rtl/evt_lim_core.sv
module evt_lim_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hit,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] nxt;
  logic             step;

  assign nxt   = count + ONE;
  assign step  = en & hit;
  assign match = step & (nxt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)            count <= '0;
    else if (load && !en)  count <= load_val;
    else if (step)         count <= nxt;
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(count)); // R4
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit) |=> (count == $past(count) + ONE)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit) |=> $stable(count)); // R3
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !en) |=> (count == $past(load_val))); // R2
endmodule

// File: rtl/evt_lim_regs.sv
module evt_lim_regs
  import evt_lim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             match,
  input  logic [CNT_W-1:0] count,
  output logic             en,
  output logic             ie,
  output logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] snap,
  output logic             flag
);
  logic clr;
  assign clr = wr_en && (wr_addr == A_STAT) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; ie <= 1'b0; sel <= '0;
      limit <= '0; snap <= '0; flag <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        en  <= wr_data[0];
        ie  <= wr_data[1];
        sel <= wr_data[2 +: SEL_W];
      end
      if (wr_en && wr_addr == A_LIMIT) limit <= wr_data;
      if (wr_en && wr_addr == A_TRIG)  snap  <= count;
      if (match)      flag <= 1'b1;
      else if (clr)   flag <= 1'b0;
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R7
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !match) |=> !flag); // R5
  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_TRIG) |=> (snap == $past(count))); // R9
endmodule

// File: rtl/evt_lim_counter.sv
module evt_lim_counter
  import evt_lim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [EVT_W-1:0] evt_in,
  output logic             irq
);
  localparam int SEL_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic             en, ie, flag, hit, match, load;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] limit, snap, count, ctrl_rd;

  assign load = wr_en && (wr_addr == A_START);

  evt_lim_mux #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_mux (
    .evt(evt_in), .sel(sel), .hit(hit));

  evt_lim_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .hit(hit), .load(load),
    .load_val(wr_data), .limit(limit), .count(count), .match(match));

  evt_lim_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .match(match), .count(count), .en(en), .ie(ie),
    .sel(sel), .limit(limit), .snap(snap), .flag(flag));

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[0] = en;
    ctrl_rd[1] = ie;
    ctrl_rd[2 +: SEL_W] = sel;
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_rd;
      A_LIMIT: rd_data = limit;
      A_SNAP:  rd_data = snap;
      A_STAT:  rd_data = CNT_W'(flag);
      default: rd_data = '0;
    endcase
  end

  assign irq = flag & ie;

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq); // R8
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_addr != A_STAT || rd_data[0])); // R8
endmodule

// File: tb/tb_evt_lim_counter.sv
module tb_evt_lim_counter;
  localparam int CNT_W = 16;
  localparam int EVT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [2:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic [EVT_W-1:0] evt_in = '0;
  logic             irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  evt_lim_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_in(evt_in), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic snap_of(output int v);
    wr(3'd3, '0);
    rd(3'd4, v);
  endtask

  initial begin : main
    int v;
    int expc;
    logic [15:0] lfsr;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd2, v); chk("R1 limit", v, 0);
    rd(3'd4, v); chk("R1 snap", v, 0);
    rd(3'd5, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(irq), 0);
    snap_of(v); chk("R1 count", v, 0);
    rd(3'd1, v); chk("R11 unmapped read", v, 0);

    // R3 sweep: every select with three patterns
    wr(3'd2, 16'hFFFF);
    lfsr = 16'hACE1;
    for (int s = 0; s < EVT_W; s++) begin
      for (int p = 0; p < 3; p++) begin
        expc = s * 1000 + p * 100;
        wr(3'd1, CNT_W'(expc));
        wr(3'd0, CNT_W'((s << 2) | 1));
        for (int c = 0; c < 40; c++) begin
          logic [EVT_W-1:0] pat;
          if (p == 0) begin
            pat = lfsr[7:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          end else if (p == 1) pat = '1;
          else pat = EVT_W'(1) << (c % EVT_W);
          evt_in = pat;
          if (pat[s]) expc++;
          @(negedge clk);
        end
        evt_in = '0;
        wr(3'd0, CNT_W'(s << 2));
        snap_of(v); chk("R3 sweep count", v, expc & 16'hFFFF);
      end
    end
    rd(3'd0, v); chk("R11 ctrl readback", v, (EVT_W - 1) << 2);

    // R4 hold while disabled
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd77);
    evt_in = '1;
    repeat (6) @(negedge clk);
    evt_in = '0;
    snap_of(v); chk("R4 hold", v, 77);

    // R5/R6/R8/R9 limit crossing
    wr(3'd2, 16'd13);
    wr(3'd1, 16'd10);
    wr(3'd5, 16'd1);
    wr(3'd0, 16'd3);
    evt_in = 8'h01;
    @(negedge clk); @(negedge clk);
    chk("R8 irq before limit", int'(irq), 0);
    @(negedge clk);
    chk("R5 irq at limit", int'(irq), 1);
    wr(3'd3, '0);
    evt_in = '0;
    rd(3'd4, v); chk("R9 pre-edge snapshot", v, 13);
    evt_in = 8'h01;
    repeat (4) @(negedge clk);
    evt_in = '0;
    snap_of(v); chk("R6 counts past limit", v, 18);
    rd(3'd5, v); chk("R7 sticky", v, 1);
    wr(3'd5, 16'd0);
    rd(3'd5, v); chk("R7 write 0 no effect", v, 1);
    wr(3'd0, 16'd1);
    chk("R8 masked irq", int'(irq), 0);
    rd(3'd5, v); chk("R8 flag kept when masked", v, 1);
    wr(3'd5, 16'd1);
    rd(3'd5, v); chk("R7 clear", v, 0);

    // R2 load ignored while enabled
    wr(3'd1, 16'd99);
    snap_of(v); chk("R2 load ignored", v, 18);

    // R7 set wins over clear
    wr(3'd2, 16'd19);
    evt_in = 8'h01;
    wr(3'd5, 16'd1);
    evt_in = '0;
    rd(3'd5, v); chk("R7 set wins", v, 1);

    // R5 load equal to limit does not flag
    wr(3'd0, 16'd0);
    wr(3'd5, 16'd1);
    wr(3'd2, 16'd50);
    wr(3'd1, 16'd50);
    rd(3'd5, v); chk("R5 load no flag", v, 0);
    snap_of(v); chk("R2 load value", v, 50);

    // R10 wrap
    wr(3'd1, 16'hFFFE);
    wr(3'd2, 16'd5);
    wr(3'd0, 16'd1);
    evt_in = 8'h01;
    repeat (3) @(negedge clk);
    evt_in = '0;
    rd(3'd5, v); chk("R10 wrap no flag", v, 0);
    snap_of(v); chk("R10 wrapped count", v, 1);

    done = 1'b1;
  end

  initial begin : finisher
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule